// File: doc/BRIEF.md
# Serial FIFO Extension Interrupt Controller

This block is the register and interrupt unit that sits next to a 16550-style UART whose receive and transmit paths are extended by large external FIFOs. A byte-wide host bus reaches five byte registers at offsets 0 to 4. Through them the host sets the operating mode, chooses which interrupt sources are enabled, reads a status byte, pulses a reset into the external FIFOs, and programs a one-shot interval timer. The FIFO storage, the UART and the serial shifting are outside the block. The block sees them only as level flags (empty, half full, full), a character-timeout event, and strobes for Rx data reads and Tx data writes.

Each interrupt source is latched and cleared by its own rule. The character timeout clears when the Rx data port or the status byte is read. Tx empty clears when the Tx FIFO is written or the status byte is read. Tx half clears when the status byte is read or when the FIFO refills to half. The timer clears only when the host disables the timer. Rx half is not latched and follows its flag directly. The enabled sources are ORed into a single interrupt line. That line is either a level or a one-clock pulse on each rise of the OR.

Top module: `sfx_irq_ctrl`

## Requirements
- R1: After synchronous reset, offsets 0, 1, 3 and 4 read 0x00, irqOut is 0 and fifoRst is 0. The status byte reads only its live flags, which gives 0x20 when all flag inputs are low.
- R2: Offset 0 (mode) stores bits 4, 3, 2 and 0 and reads them back. Bit 1 always reads 0. Bit 4 selects level (1) or edge (0) interrupt output. Bits 3, 2 and 0 drive modeFlowCtl, modeFifoEn and modeSwap.
- R3: Offset 1 (enable) stores bits 4..0 and reads bits 7..5 as 0. Bit 4 enables timer, bit 3 character timeout, bit 2 Tx empty, bit 1 Tx half, bit 0 Rx half.
- R4: A read of offset 2 returns {timer flag, char-timeout flag, NOT rxFull, rxHalf, rxEmpty, txFull, txHalf, txEmpty} from bit 7 down to bit 0. Bit 5 is therefore 0 when the Rx FIFO is full.
- R5: A write to offset 2 changes no register and drives fifoRst high for exactly the one cycle after the write edge.
- R6: Offset 3 holds interval n and offset 4 bit 0 enables the timer. The timer flag sets n×PRESC clock cycles after the enable write edge, where PRESC = CLK_HZ/TICK_HZ. The value n = 0 behaves as n = 1. Offset 4 reads back only bit 0.
- R7: The timer flag stays set through status reads and is cleared only by writing 0 to offset 4 bit 0. It does not set again until the timer is re-enabled.
- R8: A charTimeout pulse sets the char-timeout flag. A read of the Rx data port (rxDataRd) or of the status byte clears it. A new event in the same cycle as a clearing read leaves the flag set.
- R9: The Tx-empty flag sets on a 0-to-1 change of txEmpty. It clears on txDataWr or on a status read. A txEmpty that merely stays high does not set it again.
- R10: The Tx-half flag sets on a 1-to-0 change of txHalf. It clears on a status read or while txHalf is high.
- R11: The Rx-half source is the live rxHalf level. It is not latched and a status read does not clear it.
- R12: In level mode, irqOut equals the OR of enabled sources delayed by one register. A source whose enable bit is 0 never raises irqOut.
- R13: In edge mode, irqOut is high for exactly one cycle each time the registered OR of enabled sources rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| busAddr | input | 3 | Register offset |
| busWdata | input | 8 | Write data |
| busWr | input | 1 | Register write strobe |
| busRd | input | 1 | Register read strobe (side effects on status read) |
| busRdata | output | 8 | Read data for busAddr |
| rxDataRd | input | 1 | Host read of the Rx FIFO data port |
| txDataWr | input | 1 | Host write to the Tx FIFO data port |
| rxEmpty | input | 1 | Rx FIFO empty flag |
| rxHalf | input | 1 | Rx FIFO at least half full |
| rxFull | input | 1 | Rx FIFO full flag |
| txEmpty | input | 1 | Tx FIFO empty flag |
| txHalf | input | 1 | Tx FIFO at least half full |
| txFull | input | 1 | Tx FIFO full flag |
| charTimeout | input | 1 | Character-timeout event pulse |
| irqOut | output | 1 | Interrupt line, level or pulse |
| fifoRst | output | 1 | One-cycle reset pulse to the external FIFOs |
| modeFlowCtl | output | 1 | Automatic RTS/CTS flow control enable |
| modeFifoEn | output | 1 | External FIFO enable |
| modeSwap | output | 1 | Swap 8-byte halves of the 16-byte window |

## Verification
The collision of interest is a character-timeout event arriving in the same cycle as a status read that would clear that flag. The bench raises charTimeout and the offset-2 read strobe on the same clock. It expects that read to return bit 6 as 0, because the flag is not yet set. It then expects a second status read to return bit 6 as 1, which shows that the new event won over the clear. A similar overlap exists between a Tx-empty rise and a Tx data write. The bench separates those two, so that each clear rule is judged on its own at the interrupt pin.

// File: rtl/sfx_pkg.sv
`timescale 1ns/1ps
package sfx_pkg;
  localparam int REG_W  = 8;
  localparam int ADDR_W = 3;
  localparam int NSRC   = 5;

  localparam logic [ADDR_W-1:0] OFS_MODE = 3'd0;
  localparam logic [ADDR_W-1:0] OFS_IEN  = 3'd1;
  localparam logic [ADDR_W-1:0] OFS_STAT = 3'd2;
  localparam logic [ADDR_W-1:0] OFS_TIV  = 3'd3;
  localparam logic [ADDR_W-1:0] OFS_TCTL = 3'd4;

  // mode bit positions
  localparam int MB_LEVEL = 4;
  localparam int MB_FLOW  = 3;
  localparam int MB_FIFO  = 2;
  localparam int MB_SWAP  = 0;

  typedef struct packed {
    logic wrMode;
    logic wrIen;
    logic wrFifoRst;
    logic wrTiv;
    logic wrTctl;
    logic rdStatus;
  } sfx_strobe_t;
endpackage

// File: rtl/sfx_timer.sv
`timescale 1ns/1ps
module sfx_timer #(
  parameter int CLK_HZ  = 200_000_000,
  parameter int TICK_HZ = 5000,
  parameter int CNT_W   = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [CNT_W-1:0] interval,
  output logic             fire
);
  localparam int PRESC_MAX = (CLK_HZ / TICK_HZ > 0) ? CLK_HZ / TICK_HZ : 1;
  localparam int PRESC_W   = (PRESC_MAX > 1) ? $clog2(PRESC_MAX) : 1;

  logic [PRESC_W-1:0] prescQ;
  logic [CNT_W-1:0]   tickCntQ;
  logic               doneQ;
  logic               tick;
  logic [CNT_W-1:0]   nEff;

  assign nEff = (interval == '0) ? CNT_W'(1) : interval;
  assign tick = (prescQ == PRESC_W'(PRESC_MAX - 1));
  assign fire = en && !doneQ && tick && (tickCntQ <= CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      prescQ   <= '0;
      tickCntQ <= '0;
      doneQ    <= 1'b0;
    end else if (!en) begin
      prescQ   <= '0;
      tickCntQ <= nEff;
      doneQ    <= 1'b0;
    end else if (!doneQ) begin
      prescQ <= tick ? '0 : prescQ + PRESC_W'(1);
      if (tick) begin
        if (tickCntQ <= CNT_W'(1)) doneQ <= 1'b1;
        else                       tickCntQ <= tickCntQ - CNT_W'(1);
      end
    end
  end

  // R7: once expired the timer stays silent while still enabled
  a_r7_no_refire: assert property (@(posedge clk) disable iff (rst)
    (doneQ && en) |=> !fire);
endmodule

// File: rtl/sfx_datapath.sv
`timescale 1ns/1ps
module sfx_datapath
  import sfx_pkg::*;
#(
  parameter int CLK_HZ  = 200_000_000,
  parameter int TICK_HZ = 5000
) (
  input  logic              clk,
  input  logic              rst,
  input  sfx_strobe_t       stb,
  input  logic [REG_W-1:0]  wdata,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [REG_W-1:0]  rdata,
  input  logic              rxDataRd,
  input  logic              txDataWr,
  input  logic              rxEmpty,
  input  logic              rxHalf,
  input  logic              rxFull,
  input  logic              txEmpty,
  input  logic              txHalf,
  input  logic              txFull,
  input  logic              charTimeout,
  output logic              fifoRst,
  output logic              modeLevel,
  output logic              modeFlowCtl,
  output logic              modeFifoEn,
  output logic              modeSwap,
  output logic              irqAny
);
  logic [NSRC-1:0]  modeQ;
  logic [NSRC-1:0]  ienQ;
  logic [REG_W-1:0] tivQ;
  logic             tctlEnQ;
  logic             fifoRstQ;

  logic tmrQ, ctoQ, txeQ, txhQ;
  logic txEmptyPrevQ, txHalfPrevQ;
  logic txEmptyRise, txHalfFall, tmrFire;
  logic [NSRC-1:0]  srcVec;
  logic [REG_W-1:0] statusByte;

  sfx_timer #(.CLK_HZ(CLK_HZ), .TICK_HZ(TICK_HZ), .CNT_W(REG_W)) timer_i (
    .clk      (clk),
    .rst      (rst),
    .en       (tctlEnQ),
    .interval (tivQ),
    .fire     (tmrFire)
  );

  assign txEmptyRise = txEmpty && !txEmptyPrevQ;
  assign txHalfFall  = !txHalf && txHalfPrevQ;

  // host registers
  always_ff @(posedge clk) begin
    if (rst) begin
      modeQ    <= '0;
      ienQ     <= '0;
      tivQ     <= '0;
      tctlEnQ  <= 1'b0;
      fifoRstQ <= 1'b0;
    end else begin
      if (stb.wrMode) modeQ <= {wdata[MB_LEVEL:MB_FIFO], 1'b0, wdata[MB_SWAP]};
      if (stb.wrIen)  ienQ  <= wdata[NSRC-1:0];
      if (stb.wrTiv)  tivQ  <= wdata;
      if (stb.wrTctl) tctlEnQ <= wdata[0];
      fifoRstQ <= stb.wrFifoRst;
    end
  end

  // latched interrupt sources, each with its own clear rule
  always_ff @(posedge clk) begin
    if (rst) begin
      tmrQ         <= 1'b0;
      ctoQ         <= 1'b0;
      txeQ         <= 1'b0;
      txhQ         <= 1'b0;
      txEmptyPrevQ <= 1'b0;
      txHalfPrevQ  <= 1'b0;
    end else begin
      txEmptyPrevQ <= txEmpty;
      txHalfPrevQ  <= txHalf;

      if (!tctlEnQ)     tmrQ <= 1'b0;
      else if (tmrFire) tmrQ <= 1'b1;

      if (charTimeout)                    ctoQ <= 1'b1;
      else if (rxDataRd || stb.rdStatus)  ctoQ <= 1'b0;

      if (txEmptyRise)                    txeQ <= 1'b1;
      else if (txDataWr || stb.rdStatus)  txeQ <= 1'b0;

      if (txHalfFall)                     txhQ <= 1'b1;
      else if (txHalf || stb.rdStatus)    txhQ <= 1'b0;
    end
  end

  assign srcVec = {tmrQ, ctoQ, txeQ, txhQ, rxHalf};
  assign irqAny = |(srcVec & ienQ);

  assign statusByte = {tmrQ, ctoQ, !rxFull, rxHalf, rxEmpty, txFull, txHalf, txEmpty};

  always_comb begin
    rdata = '0;
    case (rdAddr)
      OFS_MODE: rdata = REG_W'(modeQ);
      OFS_IEN:  rdata = REG_W'(ienQ);
      OFS_STAT: rdata = statusByte;
      OFS_TIV:  rdata = tivQ;
      OFS_TCTL: rdata = REG_W'(tctlEnQ);
      default:  rdata = '0;
    endcase
  end

  assign fifoRst     = fifoRstQ;
  assign modeLevel   = modeQ[MB_LEVEL];
  assign modeFlowCtl = modeQ[MB_FLOW];
  assign modeFifoEn  = modeQ[MB_FIFO];
  assign modeSwap    = modeQ[MB_SWAP];

  a_r5_fifo_rst_pulse: assert property (@(posedge clk) disable iff (rst)
    stb.wrFifoRst |=> fifoRst);
  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    (rdAddr == OFS_MODE) |-> !rdata[1]);
  a_r7_timer_hold: assert property (@(posedge clk) disable iff (rst)
    (tmrQ && tctlEnQ) |=> tmrQ);
  a_r7_timer_clear: assert property (@(posedge clk) disable iff (rst)
    (stb.wrTctl && !wdata[0]) |=> ##1 !tmrQ);
  a_r8_cto_clear: assert property (@(posedge clk) disable iff (rst)
    ((stb.rdStatus || rxDataRd) && !charTimeout) |=> !ctoQ);
  a_r9_txe_clear: assert property (@(posedge clk) disable iff (rst)
    (txDataWr && !txEmptyRise) |=> !txeQ);
endmodule

// File: rtl/sfx_ctrl.sv
`timescale 1ns/1ps
module sfx_ctrl
  import sfx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic              irqAny,
  input  logic              modeLevel,
  output sfx_strobe_t       stb,
  output logic              irqOut
);
  logic irqLvlQ, irqPrevQ;

  always_comb begin
    stb           = '0;
    stb.wrMode    = busWr && (busAddr == OFS_MODE);
    stb.wrIen     = busWr && (busAddr == OFS_IEN);
    stb.wrFifoRst = busWr && (busAddr == OFS_STAT);
    stb.wrTiv     = busWr && (busAddr == OFS_TIV);
    stb.wrTctl    = busWr && (busAddr == OFS_TCTL);
    stb.rdStatus  = busRd && (busAddr == OFS_STAT);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irqLvlQ  <= 1'b0;
      irqPrevQ <= 1'b0;
    end else begin
      irqLvlQ  <= irqAny;
      irqPrevQ <= irqLvlQ;
    end
  end

  assign irqOut = modeLevel ? irqLvlQ : (irqLvlQ && !irqPrevQ);

  a_r13_edge_one_cycle: assert property (@(posedge clk) disable iff (rst)
    (!modeLevel && irqOut) |=> (!irqOut || modeLevel));
  a_r12_level_source: assert property (@(posedge clk) disable iff (rst)
    (modeLevel && irqOut) |-> $past(irqAny));
endmodule

// File: rtl/sfx_irq_ctrl.sv
`timescale 1ns/1ps
module sfx_irq_ctrl
  import sfx_pkg::*;
#(
  parameter int CLK_HZ  = 200_000_000,
  parameter int TICK_HZ = 5000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [REG_W-1:0]  busWdata,
  input  logic              busWr,
  input  logic              busRd,
  output logic [REG_W-1:0]  busRdata,
  input  logic              rxDataRd,
  input  logic              txDataWr,
  input  logic              rxEmpty,
  input  logic              rxHalf,
  input  logic              rxFull,
  input  logic              txEmpty,
  input  logic              txHalf,
  input  logic              txFull,
  input  logic              charTimeout,
  output logic              irqOut,
  output logic              fifoRst,
  output logic              modeFlowCtl,
  output logic              modeFifoEn,
  output logic              modeSwap
);
  sfx_strobe_t stb;
  logic irqAny, modeLevel;

  sfx_ctrl ctrl_i (
    .clk       (clk),
    .rst       (rst),
    .busAddr   (busAddr),
    .busWr     (busWr),
    .busRd     (busRd),
    .irqAny    (irqAny),
    .modeLevel (modeLevel),
    .stb       (stb),
    .irqOut    (irqOut)
  );

  sfx_datapath #(.CLK_HZ(CLK_HZ), .TICK_HZ(TICK_HZ)) dp_i (
    .clk         (clk),
    .rst         (rst),
    .stb         (stb),
    .wdata       (busWdata),
    .rdAddr      (busAddr),
    .rdata       (busRdata),
    .rxDataRd    (rxDataRd),
    .txDataWr    (txDataWr),
    .rxEmpty     (rxEmpty),
    .rxHalf      (rxHalf),
    .rxFull      (rxFull),
    .txEmpty     (txEmpty),
    .txHalf      (txHalf),
    .txFull      (txFull),
    .charTimeout (charTimeout),
    .fifoRst     (fifoRst),
    .modeLevel   (modeLevel),
    .modeFlowCtl (modeFlowCtl),
    .modeFifoEn  (modeFifoEn),
    .modeSwap    (modeSwap),
    .irqAny      (irqAny)
  );
endmodule

// File: tb/sfx_irq_ctrl_tb.sv
`timescale 1ns/1ps
module sfx_irq_ctrl_tb_top;
  localparam int TB_CLK_HZ = 100_000;
  localparam int TB_PRESC  = TB_CLK_HZ / 5000;   // 20 cycles per tick

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst;
  logic [2:0] busAddr;
  logic [7:0] busWdata, busRdata;
  logic       busWr, busRd, rxDataRd, txDataWr;
  logic       rxEmpty, rxHalf, rxFull, txEmpty, txHalf, txFull, charTimeout;
  logic       irqOut, fifoRst, modeFlowCtl, modeFifoEn, modeSwap;

  sfx_irq_ctrl #(.CLK_HZ(TB_CLK_HZ), .TICK_HZ(5000)) dut_i (
    .clk(clk), .rst(rst), .busAddr(busAddr), .busWdata(busWdata),
    .busWr(busWr), .busRd(busRd), .busRdata(busRdata),
    .rxDataRd(rxDataRd), .txDataWr(txDataWr),
    .rxEmpty(rxEmpty), .rxHalf(rxHalf), .rxFull(rxFull),
    .txEmpty(txEmpty), .txHalf(txHalf), .txFull(txFull),
    .charTimeout(charTimeout), .irqOut(irqOut), .fifoRst(fifoRst),
    .modeFlowCtl(modeFlowCtl), .modeFifoEn(modeFifoEn), .modeSwap(modeSwap)
  );

  typedef struct {
    logic [7:0] exp;
    logic [7:0] mask;
    string      tag;
  } rdItem_t;

  rdItem_t rdQ[$];
  int nCmp = 0;
  int nBad = 0;
  bit finished = 0;

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic checkBit(input logic act, input logic exp, input string tag);
    check({7'd0, act}, {7'd0, exp}, tag);
  endtask

  // monitor: pops expected read data and compares mid-cycle
  always @(negedge clk) begin
    rdItem_t it;
    if (busRd && !rst) begin
      if (rdQ.size() == 0) begin
        nCmp++; nBad++;
        $display("FAIL scoreboard: actual read %h expected none queued", busRdata);
      end else begin
        it = rdQ.pop_front();
        check(busRdata & it.mask, it.exp & it.mask, it.tag);
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    busAddr = a; busWdata = d; busWr = 1'b1;
    @(posedge clk); #1;
    busWr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] exp, input logic [7:0] mask,
                    input string tag);
    rdItem_t it;
    @(posedge clk); #1;
    busAddr = a; busRd = 1'b1;
    it.exp = exp; it.mask = mask; it.tag = tag;
    rdQ.push_back(it);
    @(posedge clk); #1;
    busRd = 1'b0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nCmp++; nBad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    rdItem_t it;
    rst = 1'b1; busAddr = '0; busWdata = '0; busWr = 0; busRd = 0;
    rxDataRd = 0; txDataWr = 0; charTimeout = 0;
    rxEmpty = 0; rxHalf = 0; rxFull = 0; txEmpty = 0; txHalf = 0; txFull = 0;
    step(4);
    rst = 1'b0;
    step(1);

    // R1 reset state
    checkBit(irqOut, 1'b0, "R1 irqOut");
    checkBit(fifoRst, 1'b0, "R1 fifoRst");
    rd(3'd0, 8'h00, 8'hFF, "R1 mode");
    rd(3'd1, 8'h00, 8'hFF, "R1 ien");
    rd(3'd2, 8'h20, 8'hFF, "R1 status");
    rd(3'd3, 8'h00, 8'hFF, "R1 tiv");
    rd(3'd4, 8'h00, 8'hFF, "R1 tctl");

    // R2 mode register
    wr(3'd0, 8'hFF);
    rd(3'd0, 8'h1D, 8'hFF, "R2 mode all ones");
    check({5'd0, modeFlowCtl, modeFifoEn, modeSwap}, 8'h07, "R2 mode outputs");
    wr(3'd0, 8'h0A);
    rd(3'd0, 8'h08, 8'hFF, "R2 reserved bit");
    check({5'd0, modeFlowCtl, modeFifoEn, modeSwap}, 8'h04, "R2 mode outputs b");

    // R3 enable register
    wr(3'd1, 8'hFF);
    rd(3'd1, 8'h1F, 8'hFF, "R3 ien");
    wr(3'd1, 8'h00);

    // R6 interval and control readback
    wr(3'd3, 8'hA5);
    rd(3'd3, 8'hA5, 8'hFF, "R6 tiv");
    wr(3'd4, 8'hFE);
    rd(3'd4, 8'h00, 8'hFF, "R6 tctl bit0 only");

    // R5 fifo reset pulse, no register change
    checkBit(fifoRst, 1'b0, "R5 before");
    wr(3'd2, 8'h5A);
    checkBit(fifoRst, 1'b1, "R5 pulse");
    step(1);
    checkBit(fifoRst, 1'b0, "R5 one cycle");
    rd(3'd0, 8'h08, 8'hFF, "R5 mode kept");
    rd(3'd3, 8'hA5, 8'hFF, "R5 tiv kept");

    // R4 status layout, two patterns
    rxFull = 0; rxHalf = 1; rxEmpty = 0; txFull = 1; txHalf = 0; txEmpty = 1;
    step(1);
    rd(3'd2, 8'h35, 8'h3F, "R4 pattern a");
    rxFull = 1; rxHalf = 0; rxEmpty = 1; txFull = 0; txHalf = 0; txEmpty = 0;
    step(1);
    rd(3'd2, 8'h08, 8'h3F, "R4 pattern b rx full");
    rxFull = 0; rxEmpty = 0;
    rd(3'd2, 8'h20, 8'hFF, "R4 clean");

    // R6/R7 timer, level mode with timer enabled
    wr(3'd0, 8'h10);
    wr(3'd1, 8'h10);
    wr(3'd3, 8'd2);
    wr(3'd4, 8'h01);
    step(2 * TB_PRESC - 2);
    rd(3'd2, 8'h00, 8'h80, "R6 not yet expired");
    rd(3'd2, 8'h80, 8'h80, "R6 expired at n*PRESC");
    rd(3'd2, 8'h80, 8'h80, "R7 survives status read");
    checkBit(irqOut, 1'b1, "R12 timer irq level");
    wr(3'd4, 8'h00);
    rd(3'd2, 8'h00, 8'h80, "R7 cleared by disable");
    step(1);
    checkBit(irqOut, 1'b0, "R7 irq dropped");
    step(3 * TB_PRESC);
    rd(3'd2, 8'h00, 8'h80, "R7 no refire while disabled");
    wr(3'd3, 8'd0);
    wr(3'd4, 8'h01);
    step(TB_PRESC - 2);
    rd(3'd2, 8'h00, 8'h80, "R6 n=0 not yet");
    rd(3'd2, 8'h80, 8'h80, "R6 n=0 acts as 1");
    wr(3'd4, 8'h00);
    wr(3'd1, 8'h00);

    // R8 char timeout
    @(posedge clk); #1; charTimeout = 1;
    @(posedge clk); #1; charTimeout = 0;
    rd(3'd2, 8'h40, 8'h40, "R8 set");
    rd(3'd2, 8'h00, 8'h40, "R8 cleared by status read");
    @(posedge clk); #1; charTimeout = 1;
    @(posedge clk); #1; charTimeout = 0;
    @(posedge clk); #1; rxDataRd = 1;
    @(posedge clk); #1; rxDataRd = 0;
    rd(3'd2, 8'h00, 8'h40, "R8 cleared by rx data read");
    // collision: event and clearing status read together
    @(posedge clk); #1;
    charTimeout = 1; busAddr = 3'd2; busRd = 1;
    it.exp = 8'h00; it.mask = 8'h40; it.tag = "R8 collision read";
    rdQ.push_back(it);
    @(posedge clk); #1;
    charTimeout = 0; busRd = 0;
    rd(3'd2, 8'h40, 8'h40, "R8 set wins over clear");
    rd(3'd2, 8'h00, 8'h40, "R8 final clear");

    // R9 tx empty, level mode
    wr(3'd1, 8'h04);
    step(1);
    txEmpty = 1;
    step(2);
    checkBit(irqOut, 1'b1, "R9 set on rise");
    @(posedge clk); #1; txDataWr = 1;
    @(posedge clk); #1; txDataWr = 0;
    step(1);
    checkBit(irqOut, 1'b0, "R9 cleared by tx write");
    step(5);
    checkBit(irqOut, 1'b0, "R9 steady high no reset");
    txEmpty = 0;
    step(2);
    txEmpty = 1;
    step(2);
    checkBit(irqOut, 1'b1, "R9 set again");
    rd(3'd2, 8'h01, 8'h01, "R9 status");
    step(1);
    checkBit(irqOut, 1'b0, "R9 cleared by status read");
    txEmpty = 0;

    // R10 tx half
    wr(3'd1, 8'h02);
    txHalf = 1;
    step(2);
    checkBit(irqOut, 1'b0, "R10 rise does not set");
    txHalf = 0;
    step(2);
    checkBit(irqOut, 1'b1, "R10 set on fall");
    txHalf = 1;
    step(2);
    checkBit(irqOut, 1'b0, "R10 cleared by refill");
    txHalf = 0;
    step(2);
    checkBit(irqOut, 1'b1, "R10 set again");
    rd(3'd2, 8'h00, 8'h02, "R10 status");
    step(1);
    checkBit(irqOut, 1'b0, "R10 cleared by status read");

    // R11/R12 rx half, enable gating
    wr(3'd1, 8'h00);
    rxHalf = 1;
    step(3);
    checkBit(irqOut, 1'b0, "R12 disabled source");
    wr(3'd1, 8'h01);
    step(2);
    checkBit(irqOut, 1'b1, "R11 rx half level");
    rd(3'd2, 8'h10, 8'h10, "R11 status");
    step(2);
    checkBit(irqOut, 1'b1, "R11 status read no clear");
    rxHalf = 0;
    step(1);
    checkBit(irqOut, 1'b0, "R11 follows level");

    // R13 edge mode pulse
    wr(3'd0, 8'h00);
    wr(3'd1, 8'h04);
    step(1);
    txEmpty = 1;
    step(1);
    checkBit(irqOut, 1'b0, "R13 before");
    step(1);
    checkBit(irqOut, 1'b1, "R13 pulse");
    step(1);
    checkBit(irqOut, 1'b0, "R13 one cycle");
    step(3);
    checkBit(irqOut, 1'b0, "R13 no repeat");

    step(2);
    check(8'(rdQ.size()), 8'h00, "scoreboard drained");
    summary();
  end
endmodule